// File: doc/BRIEF.md
# Light Sensor Integration Timing Controller

This block runs back-to-back integration periods for a two-channel integrating light converter. A two-bit timing select sets the period length, counted in oscillator clocks as a multiple of a fixed unit (`UNIT_CYCLES`, default 918). During a period, each channel turns its single-cycle count requests into counts in a private accumulator. The accumulator accepts at most one count every second clock.

When the period closes, the block removes a fixed two-count offset from each total. A total below the offset becomes zero. The result is then limited to the largest `CNT_W`-bit value. Both channel results are loaded into the output registers on the same clock edge, together with a one-cycle valid strobe.

On each update, the new channel 0 result is compared with a low bound and a high bound. A result outside those bounds sets a sticky interrupt flag. The flag stays set until software pulses the clear input. The flag drives the enable of an active-low, open-drain interrupt pin. When the power enable is low, the period counter and the accumulators are held at zero. The output registers and the interrupt flag keep their values.

Top module: `light_integ_ctrl`

## Requirements
- R1: `int_sel` sets the period length: 2'b00 gives 11×`UNIT_CYCLES` clocks, 2'b01 gives 81×`UNIT_CYCLES`, and 2'b10 gives 322×`UNIT_CYCLES`. While the block runs without interruption, successive `data_valid` strobes are exactly one period length apart.
- R2: A channel accumulator adds at most one count in any two consecutive clocks. A request (`chan_req[0]` for channel 0, `chan_req[1]` for channel 1) arriving in the clock right after an accepted request is dropped. A request held high for a whole period of length L therefore gives L/2 counts.
- R3: Each published result is the accumulated count minus 2. A count of 0 or 1 publishes 0.
- R4: A result larger than 2^`CNT_W`−1 publishes 2^`CNT_W`−1.
- R5: `ch0_data` and `ch1_data` change together, on the same edge that raises `data_valid`, and hold their values at all other times. `data_valid` is high for exactly one clock per period.
- R6: `int_sel` = 2'b11 is reserved. While it is selected, the period counter and the accumulators hold, requests are dropped, and no update occurs. Selecting a valid length again resumes the same period from where it stopped.
- R7: With `pwr_en` low, the period counter and the accumulators clear. `ch0_data`, `ch1_data` and the interrupt flag keep their values. The first period after `pwr_en` returns high is a full-length period.
- R8: On each update, a new channel 0 result below `thr_lo` or above `thr_hi` sets `irq_pull_low` at the same edge as the data update. A result inside the bounds leaves the flag unchanged, so a set flag stays set.
- R9: A one-clock pulse on `irq_clr` clears the flag on the next edge. If a set condition and a clear occur in the same clock, the flag ends set.
- R10: While `rst` is high, `ch0_data`, `ch1_data`, `data_valid` and `irq_pull_low` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_en | input | 1 | Power enable; low clears the counter and the accumulators |
| int_sel | input | 2 | Integration length select (11 is reserved) |
| chan_req | input | 2 | Per-channel count requests, bit 0 = channel 0 |
| thr_lo | input | CNT_W | Lower interrupt bound for channel 0 |
| thr_hi | input | CNT_W | Upper interrupt bound for channel 0 |
| irq_clr | input | 1 | Interrupt flag clear pulse |
| ch0_data | output | CNT_W | Buffered channel 0 result |
| ch1_data | output | CNT_W | Buffered channel 1 result |
| data_valid | output | 1 | One-clock strobe on each result update |
| irq_pull_low | output | 1 | Drive-low enable for the active-low interrupt pin |

## Verification
The assertions assume that the request inputs, `int_sel`, the bounds and `irq_clr` are synchronous levels that settle before each rising edge. They also assume that the shortest period is at least two clocks long, which holds for any `UNIT_CYCLES` of one or more. The bench changes every input at the falling edge. It changes `int_sel` only at period boundaries, or across a reserved hold. It programs the bounds with `thr_lo` not above `thr_hi`. The bench uses a small unit and a 10-bit result, so saturation and all three lengths fit in a short run.

// File: rtl/lsit_pkg.sv
package lsit_pkg;
  typedef enum logic [1:0] {
    SEL_SHORT = 2'b00,
    SEL_MID   = 2'b01,
    SEL_LONG  = 2'b10,
    SEL_RSVD  = 2'b11
  } integ_sel_e;

  localparam int MULT_SHORT = 11;
  localparam int MULT_MID   = 81;
  localparam int MULT_LONG  = 322;
endpackage

// File: rtl/lsit_period_timer.sv
module lsit_period_timer
  import lsit_pkg::*;
#(
  parameter int UNIT_CYCLES = 918
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_en,
  input  logic [1:0] int_sel,
  output logic       run,
  output logic       last
);
  localparam int LEN_MAX = UNIT_CYCLES * MULT_LONG;
  localparam int CW      = $clog2(LEN_MAX);

  integ_sel_e      sel;
  logic [CW-1:0]   cnt_q;
  logic [CW-1:0]   len_m1;

  assign sel = integ_sel_e'(int_sel);

  always_comb begin
    case (sel)
      SEL_SHORT: len_m1 = CW'(UNIT_CYCLES * MULT_SHORT - 1);
      SEL_MID:   len_m1 = CW'(UNIT_CYCLES * MULT_MID - 1);
      default:   len_m1 = CW'(LEN_MAX - 1);
    endcase
  end

  assign run  = pwr_en && (sel != SEL_RSVD);
  assign last = run && (cnt_q >= len_m1);

  always_ff @(posedge clk) begin
    if (rst || !pwr_en) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= last ? '0 : cnt_q + CW'(1);
    end
  end

  // R1
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    last |=> (cnt_q == '0));

  // R6
  rsvd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_en && (int_sel == 2'b11)) |=> $stable(cnt_q));

  // R7
  pwr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_en |=> (cnt_q == '0));
endmodule

// File: rtl/lsit_chan_acc.sv
module lsit_chan_acc #(
  parameter int CNT_W  = 16,
  parameter int OFFSET = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_en,
  input  logic             run,
  input  logic             last,
  input  logic             req,
  output logic [CNT_W-1:0] res
);
  localparam int             AW      = CNT_W + 1;
  localparam logic [AW-1:0]  ACC_MAX = {AW{1'b1}};
  localparam logic [AW-1:0]  OFF_V   = AW'(OFFSET);
  localparam logic [AW-1:0]  RES_MAX = {1'b0, {CNT_W{1'b1}}};

  logic [AW-1:0] acc_q;
  logic [AW-1:0] acc_sum;
  logic [AW-1:0] trimmed;
  logic          took_q;
  logic          accept;

  assign accept  = run && req && !took_q;
  assign acc_sum = (accept && (acc_q != ACC_MAX)) ? acc_q + AW'(1) : acc_q;

  always_comb begin
    if (acc_sum < OFF_V) trimmed = '0;
    else                 trimmed = acc_sum - OFF_V;
    res = (trimmed > RES_MAX) ? {CNT_W{1'b1}} : trimmed[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || !pwr_en) begin
      acc_q  <= '0;
      took_q <= 1'b0;
    end else begin
      took_q <= accept;
      if (run) acc_q <= last ? '0 : acc_sum;
    end
  end

  // R2
  rate_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (run && took_q && !last) |=> $stable(acc_q));

  // R7
  acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_en |=> ((acc_q == '0) && !took_q));
endmodule

// File: rtl/lsit_irq.sv
module lsit_irq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [CNT_W-1:0] val,
  input  logic [CNT_W-1:0] lo,
  input  logic [CNT_W-1:0] hi,
  input  logic             clr,
  output logic             irq_q
);
  logic outside;

  assign outside = (val < lo) || (val > hi);

  always_ff @(posedge clk) begin
    if (rst)                  irq_q <= 1'b0;
    else if (upd && outside)  irq_q <= 1'b1;
    else if (clr)             irq_q <= 1'b0;
  end

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !clr) |=> irq_q);

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !upd) |=> !irq_q);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (upd && (val < lo)) |=> irq_q);
endmodule

// File: rtl/light_integ_ctrl.sv
module light_integ_ctrl #(
  parameter int UNIT_CYCLES = 918,
  parameter int CNT_W       = 16,
  parameter int OFFSET      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_en,
  input  logic [1:0]       int_sel,
  input  logic [1:0]       chan_req,
  input  logic [CNT_W-1:0] thr_lo,
  input  logic [CNT_W-1:0] thr_hi,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] ch0_data,
  output logic [CNT_W-1:0] ch1_data,
  output logic             data_valid,
  output logic             irq_pull_low
);
  localparam int NCH = 2;

  logic             run;
  logic             last;
  logic [CNT_W-1:0] res [NCH];

  lsit_period_timer #(.UNIT_CYCLES(UNIT_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .pwr_en  (pwr_en),
    .int_sel (int_sel),
    .run     (run),
    .last    (last)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    lsit_chan_acc #(.CNT_W(CNT_W), .OFFSET(OFFSET)) u_acc (
      .clk    (clk),
      .rst    (rst),
      .pwr_en (pwr_en),
      .run    (run),
      .last   (last),
      .req    (chan_req[g]),
      .res    (res[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ch0_data   <= '0;
      ch1_data   <= '0;
      data_valid <= 1'b0;
    end else begin
      data_valid <= last;
      if (last) begin
        ch0_data <= res[0];
        ch1_data <= res[1];
      end
    end
  end

  lsit_irq #(.CNT_W(CNT_W)) u_irq (
    .clk   (clk),
    .rst   (rst),
    .upd   (last),
    .val   (res[0]),
    .lo    (thr_lo),
    .hi    (thr_hi),
    .clr   (irq_clr),
    .irq_q (irq_pull_low)
  );

  // R5
  pair_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !data_valid |-> ($stable(ch0_data) && $stable(ch1_data)));

  // R5
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    data_valid |=> !data_valid);

  // R6
  rsvd_no_update_chk: assert property (@(posedge clk) disable iff (rst)
    (int_sel == 2'b11) |=> !data_valid);

  // R7
  pwr_no_update_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_en |=> !data_valid);
endmodule

// File: tb/tb_light_integ_ctrl.sv
module tb_light_integ_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int UNIT       = 8;
  localparam int CW         = 10;
  localparam int RMAX       = (1 << CW) - 1;

  typedef struct {
    int    d0;
    int    d1;
    int    len;
    bit    irq;
    string tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst;
  logic          pwr_en;
  logic [1:0]    int_sel;
  logic [1:0]    chan_req;
  logic [CW-1:0] thr_lo;
  logic [CW-1:0] thr_hi;
  logic          irq_clr;
  logic [CW-1:0] ch0_data;
  logic [CW-1:0] ch1_data;
  logic          data_valid;
  logic          irq_pull_low;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    mon_on  = 0;
  bit    prev_v  = 0;
  int    cyc     = 0;
  item_t sbq[$];

  light_integ_ctrl #(.UNIT_CYCLES(UNIT), .CNT_W(CW), .OFFSET(2)) dut (
    .clk(clk), .rst(rst), .pwr_en(pwr_en), .int_sel(int_sel),
    .chan_req(chan_req), .thr_lo(thr_lo), .thr_hi(thr_hi),
    .irq_clr(irq_clr), .ch0_data(ch0_data), .ch1_data(ch1_data),
    .data_valid(data_valid), .irq_pull_low(irq_pull_low)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  function automatic int period_len(input int sel);
    case (sel)
      0:       return UNIT * 11;
      1:       return UNIT * 81;
      default: return UNIT * 322;
    endcase
  endfunction

  // mode 0 = idle, 1 = held high, 2 = high one clock in four
  function automatic int counts(input int mode, input int len);
    case (mode)
      1:       return len / 2;
      2:       return len / 4;
      default: return 0;
    endcase
  endfunction

  function automatic int publish(input int n);
    if (n < 2) return 0;
    if (n - 2 > RMAX) return RMAX;
    return n - 2;
  endfunction

  function automatic logic mode_bit(input int mode, input int i);
    case (mode)
      1:       return 1'b1;
      2:       return (i % 4) == 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic drive(input int m0, input int m1, input int n, input int clr_at);
    for (int i = 0; i < n; i++) begin
      chan_req[0] = mode_bit(m0, i);
      chan_req[1] = mode_bit(m1, i);
      irq_clr     = (i == clr_at);
      if (clr_at >= 0 && i == clr_at + 1)
        chk(irq_pull_low == 1'b0, "R9 flag cleared by pulse", irq_pull_low, 0);
      @(negedge clk);
    end
    chan_req = 2'b00;
    irq_clr  = 1'b0;
  endtask

  task automatic run_period(input int sel, input int m0, input int m1, input bit len_chk,
                            input bit irq_exp, input string tag, input int clr_at);
    int L;
    item_t it;
    L       = period_len(sel);
    int_sel = 2'(sel);
    it.d0   = publish(counts(m0, L));
    it.d1   = publish(counts(m1, L));
    it.len  = len_chk ? L : 0;
    it.irq  = irq_exp;
    it.tag  = tag;
    sbq.push_back(it);
    drive(m0, m1, L, clr_at);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      cyc++;
      if (data_valid) begin
        chk(!prev_v, "R5 strobe lasts one clock", prev_v, 0);
        if (sbq.size() == 0) begin
          chk(1'b0, "R6 update with none expected", ch0_data, -1);
        end else begin
          item_t it;
          it = sbq.pop_front();
          chk(ch0_data == it.d0, {it.tag, " ch0"}, ch0_data, it.d0);
          chk(ch1_data == it.d1, {it.tag, " ch1"}, ch1_data, it.d1);
          chk(irq_pull_low == it.irq, {it.tag, " irq R8"}, irq_pull_low, it.irq);
          if (it.len != 0)
            chk(cyc == it.len, {it.tag, " period R1"}, cyc, it.len);
        end
        cyc = 0;
      end
      prev_v = data_valid;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; pwr_en = 1'b1; int_sel = 2'b00; chan_req = 2'b00;
    thr_lo = '0; thr_hi = CW'(RMAX); irq_clr = 1'b0;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(ch0_data == 0 && ch1_data == 0, "R10 reset data", ch0_data, 0);
    chk(data_valid == 0, "R10 reset strobe", data_valid, 0);
    chk(irq_pull_low == 0, "R10 reset irq", irq_pull_low, 0);
    rst    = 1'b0;
    mon_on = 1'b1;

    run_period(0, 1, 1, 0, 0, "R1 R2 R3 short held", -1);
    run_period(0, 2, 0, 1, 0, "R3 short sparse/idle clamp", -1);
    run_period(1, 1, 2, 1, 0, "R1 mid length", -1);
    run_period(2, 1, 2, 1, 0, "R4 long saturation", -1);

    thr_lo = CW'(30);
    thr_hi = CW'(100);
    run_period(0, 1, 0, 1, 0, "R8 inside bounds", -1);
    run_period(0, 0, 1, 1, 1, "R8 below low bound", -1);
    run_period(0, 1, 1, 1, 1, "R8 sticky while inside", -1);
    run_period(0, 1, 1, 1, 0, "R9 mid-period clear", 10);
    run_period(1, 1, 0, 1, 1, "R8 above high bound", -1);
    run_period(0, 0, 0, 1, 1, "R9 set wins over clear", 87);

    // R6 reserved select pauses the period
    begin
      item_t it;
      it.d0 = 42; it.d1 = 42; it.len = 118; it.irq = 1'b1; it.tag = "R6 reserved hold";
      sbq.push_back(it);
      int_sel = 2'b00; drive(1, 1, 40, -1);
      int_sel = 2'b11; drive(1, 1, 30, -1);
      int_sel = 2'b00; drive(1, 1, 48, -1);
    end

    // R7 power-down clears counting, keeps results and flag
    begin
      item_t it;
      it.d0 = 42; it.d1 = 0; it.len = 128; it.irq = 1'b1; it.tag = "R7 power cycle";
      sbq.push_back(it);
      drive(1, 1, 30, -1);
      pwr_en = 1'b0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        chk(ch0_data == 42 && ch1_data == 42, "R7 results kept while off", ch0_data, 42);
        chk(irq_pull_low == 1'b1, "R7 flag kept while off", irq_pull_low, 1);
      end
      pwr_en = 1'b1;
      drive(1, 0, 88, -1);
    end

    // R6 no update at all while reserved select is held
    int_sel = 2'b11;
    drive(1, 1, 200, -1);
    chk(ch0_data == 42 && ch1_data == 0, "R6 results unchanged under reserved", ch0_data, 42);
    chk(sbq.size() == 0, "R5 all expected updates seen", sbq.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule